// File: doc/BRIEF.md
# Parity-Guarded Configuration Register Supervisor

This block keeps a small bank of configuration words. Each word is stored with one even-parity bit, which the block computes whenever the word is written. A scrub pointer walks the bank one word per clock in a fixed rotation and compares each stored word against its parity bit. Each word has its own mismatch flag. A flag is set when the scrub finds that word bad. It is cleared when the scrub finds the word clean again, or when software rewrites the word.

While any flag is set, the block holds the neighbouring local logic in reset. It also drives its active-low ready/reset output and its active-low fault output low. It withdraws the enable of the lifesign transmitter, so the partner side sees a loss of communication. It also raises a request to the emergency turn-off sequencer. That request is latched and stays high until the sequencer acknowledges it, even if the fault has already cleared.

A test input flips the stored parity bit of one word, so a mismatch can be provoked without corrupting the data itself.

Top module: `cfg_parity_guard`

## Requirements
- R1: A write stores `wr_data` at `wr_addr`, and the word appears on `rd_data` for the matching `rd_addr` from the cycle after the write. After reset every word reads 0.
- R2: The parity bit stored on a write is the XOR of all data bits (even parity). Words of any bit weight therefore raise no fault after a full scrub pass.
- R3: The scrub checks one word per clock, in the order 0, 1, … NUM_REGS-1 and then wraps. A flipped parity bit raises `core_hold` within NUM_REGS+1 clocks of the flip.
- R4: `core_hold` is 1 exactly while at least one word's mismatch flag is set.
- R5: While `core_hold` is 1, `rdy_rst_n` is 0. With DRIVE_FLT=1 (the default), `flt_n` is also 0.
- R6: `beat_en` is 0 while `core_hold` is 1, and 1 otherwise.
- R7: `trip_req` rises one clock after `core_hold` rises. It stays 1 until a clock at which `trip_ack` is 1 and no fault is present. An acknowledge given during a fault has no effect.
- R8: Rewriting a faulty word clears its flag at the write edge. A fault in another word keeps `core_hold` asserted.
- R9: A mismatch that disappears without a rewrite (a second flip of the same parity bit) is cleared when the scrub next visits that word.
- R10: In reset and just after it, `core_hold`=0, `rdy_rst_n`=1, `flt_n`=1, `beat_en`=1 and `trip_req`=0.
- R11: When a write and a parity flip target the same word in the same clock, the write wins and no fault results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word index for writes |
| wr_data | input | DATA_W | Data to store |
| rd_addr | input | ADDR_W | Word index for reads |
| rd_data | output | DATA_W | Stored word at `rd_addr` |
| inj_en | input | 1 | Test strobe: flip one stored parity bit |
| inj_addr | input | ADDR_W | Word whose parity bit is flipped |
| trip_ack | input | 1 | Acknowledge from the turn-off sequencer |
| core_hold | output | 1 | Holds local logic in reset, active high |
| rdy_rst_n | output | 1 | Ready/reset indication, low during a fault |
| flt_n | output | 1 | Fault indication, low during a fault |
| beat_en | output | 1 | Lifesign transmit enable |
| trip_req | output | 1 | Latched emergency turn-off request |

## Verification
The checker watches several relations on every cycle. It confirms that the ready, fault and lifesign outputs follow `core_hold`. It confirms that `trip_req` rises one cycle after a fault begins and never drops while it is unacknowledged. It also confirms that every rise of `trip_req` has a fault behind it. Other behaviour depends on the stored contents, so only the directed scenarios can show it:
- parity detection within one scrub pass;
- clearing by rewrite versus clearing by a second flip;
- several words faulted at once;
- a write and a flip colliding on the same word.

// File: rtl/cfgpg_pkg.sv
package cfgpg_pkg;
    typedef enum logic {
        TRIP_IDLE    = 1'b0,
        TRIP_LATCHED = 1'b1
    } trip_state_t;

    function automatic int unsigned addr_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/cfgpg_bank.sv
module cfgpg_bank #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             inj_en,
    input  logic [ADDR_W-1:0]                inj_addr,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  data_o,
    output logic [NUM_REGS-1:0]              par_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] data;
        logic [NUM_REGS-1:0]             par;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Test flip first, so a write to the same word overrides it.
        if (inj_en && (int'(inj_addr) < NUM_REGS)) begin
            st_d.par[inj_addr] = ~st_q.par[inj_addr];
        end
        if (wr_en && (int'(wr_addr) < NUM_REGS)) begin
            st_d.data[wr_addr] = wr_data;
            st_d.par[wr_addr]  = ^wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign par_o  = st_q.par;
endmodule

// File: rtl/cfgpg_scrub.sv
module cfgpg_scrub #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  data_i,
    input  logic [NUM_REGS-1:0]              par_i,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    output logic [NUM_REGS-1:0]              err_o
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_REGS - 1);

    typedef struct packed {
        logic [ADDR_W-1:0]   ptr;
        logic [NUM_REGS-1:0] err;
    } scrub_t;

    scrub_t st_d, st_q;
    logic   bad;

    always_comb begin
        bad  = (^data_i[st_q.ptr]) ^ par_i[st_q.ptr];
        st_d = st_q;
        st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        st_d.err[st_q.ptr] = bad;
        // A rewrite recomputes parity, so its flag clears at once.
        if (wr_en && (int'(wr_addr) < NUM_REGS)) begin
            st_d.err[wr_addr] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = st_q.err;
endmodule

// File: rtl/cfgpg_react.sv
module cfgpg_react
    import cfgpg_pkg::*;
#(
    parameter bit DRIVE_FLT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    input  logic trip_ack,
    output logic core_hold,
    output logic rdy_rst_n,
    output logic flt_n,
    output logic beat_en,
    output logic trip_req
);
    typedef struct packed {
        trip_state_t trip;
    } react_t;

    react_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fault_i) begin
            st_d.trip = TRIP_LATCHED;
        end else if (trip_ack) begin
            st_d.trip = TRIP_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{trip: TRIP_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign core_hold = fault_i;
    assign rdy_rst_n = ~fault_i;
    assign beat_en   = ~fault_i;
    assign trip_req  = (st_q.trip == TRIP_LATCHED);

    generate
        if (DRIVE_FLT) begin : g_flt
            assign flt_n = ~fault_i;
        end else begin : g_noflt
            assign flt_n = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/cfg_parity_guard.sv
module cfg_parity_guard
    import cfgpg_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int DATA_W    = 16,
    parameter bit DRIVE_FLT = 1'b1,
    parameter int ADDR_W    = addr_bits(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic              trip_ack,
    output logic              core_hold,
    output logic              rdy_rst_n,
    output logic              flt_n,
    output logic              beat_en,
    output logic              trip_req
);
    logic [NUM_REGS-1:0][DATA_W-1:0] data_w;
    logic [NUM_REGS-1:0]             par_w;
    logic [NUM_REGS-1:0]             err_w;
    logic                            fault_w;

    cfgpg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) bank_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .inj_en(inj_en), .inj_addr(inj_addr),
        .data_o(data_w), .par_o(par_w)
    );

    cfgpg_scrub #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) scrub_i (
        .clk(clk), .rst_n(rst_n),
        .data_i(data_w), .par_i(par_w),
        .wr_en(wr_en), .wr_addr(wr_addr),
        .err_o(err_w)
    );

    assign fault_w = |err_w;

    cfgpg_react #(.DRIVE_FLT(DRIVE_FLT)) react_i (
        .clk(clk), .rst_n(rst_n),
        .fault_i(fault_w), .trip_ack(trip_ack),
        .core_hold(core_hold), .rdy_rst_n(rdy_rst_n), .flt_n(flt_n),
        .beat_en(beat_en), .trip_req(trip_req)
    );

    assign rd_data = (int'(rd_addr) < NUM_REGS) ? data_w[rd_addr] : '0;
endmodule

// File: rtl/cfgpg_chk.sv
module cfgpg_chk #(
    parameter bit DRIVE_FLT = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic trip_ack,
    input logic core_hold,
    input logic rdy_rst_n,
    input logic flt_n,
    input logic beat_en,
    input logic trip_req
);
    a_r5_rdy_low: assert property (@(posedge clk) disable iff (!rst_n)
        core_hold |-> !rdy_rst_n);

    a_r5_flt_low: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold && DRIVE_FLT) |-> !flt_n);

    a_r6_beat_off: assert property (@(posedge clk) disable iff (!rst_n)
        core_hold |-> !beat_en);

    a_r6_beat_on: assert property (@(posedge clk) disable iff (!rst_n)
        !core_hold |-> beat_en);

    a_r7_trip_follows: assert property (@(posedge clk) disable iff (!rst_n)
        core_hold |=> trip_req);

    a_r7_trip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_req && !trip_ack) |=> trip_req);

    a_r7_trip_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_req) |-> $past(core_hold));

    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |-> (!core_hold && !trip_req && beat_en));
endmodule

bind cfg_parity_guard cfgpg_chk #(.DRIVE_FLT(DRIVE_FLT)) chk_i (
    .clk(clk), .rst_n(rst_n), .trip_ack(trip_ack),
    .core_hold(core_hold), .rdy_rst_n(rdy_rst_n), .flt_n(flt_n),
    .beat_en(beat_en), .trip_req(trip_req)
);

// File: tb/cfg_parity_guard_tb_top.sv
module cfg_parity_guard_tb_top;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;
    logic          inj_en = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic          trip_ack = 1'b0;
    logic          core_hold, rdy_rst_n, flt_n, beat_en, trip_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] model [N];

    always #10 clk = ~clk;

    cfg_parity_guard #(.NUM_REGS(N), .DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .inj_en(inj_en), .inj_addr(inj_addr), .trip_ack(trip_ack),
        .core_hold(core_hold), .rdy_rst_n(rdy_rst_n), .flt_n(flt_n),
        .beat_en(beat_en), .trip_req(trip_req)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk_outs(input string req, input logic flt);
        chk({req, " core_hold"}, W'(core_hold), W'(flt));
        chk({req, " rdy_rst_n"}, W'(rdy_rst_n), W'(!flt));
        chk({req, " flt_n"},     W'(flt_n),     W'(!flt));
        chk({req, " beat_en"},   W'(beat_en),   W'(!flt));
    endtask

    task automatic wr(input int a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        tick(1);
        wr_en = 1'b0;
        model[a] = d;
    endtask

    task automatic flip(input int a);
        inj_en = 1'b1; inj_addr = AW'(a);
        tick(1);
        inj_en = 1'b0;
    endtask

    task automatic ack();
        trip_ack = 1'b1;
        tick(1);
        trip_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(2);
        chk_outs("R10 in reset", 1'b0);
        chk("R10 trip in reset", W'(trip_req), '0);
        rst_n = 1'b1;
        tick(1);
        chk_outs("R10 after reset", 1'b0);
        for (int a = 0; a < N; a++) begin
            rd_addr = AW'(a); #1;
            chk("R1 reset contents", rd_data, '0);
            model[a] = '0;
        end
    endtask

    task automatic t_write_read();
        for (int a = 0; a < N; a++) begin
            wr(a, W'(16'h1357 * (a + 1)) ^ W'(a));
            rd_addr = AW'(a); #1;
            chk("R1 readback", rd_data, model[a]);
        end
        wr(2, 16'h0001);
        wr(3, 16'hFFFF);
        wr(4, 16'h0007);
        tick(N + 2);
        chk_outs("R2 mixed weights no fault", 1'b0);
        chk("R2 no trip", W'(trip_req), '0);
    endtask

    task automatic t_detect_and_rewrite();
        flip(3);
        tick(N + 1);
        chk_outs("R3 flip detected", 1'b1);
        chk("R4 hold held", W'(core_hold), 1);
        chk("R7 trip raised", W'(trip_req), 1);
        ack();
        chk("R7 ack during fault ignored", W'(trip_req), 1);
        wr(3, model[3]);
        chk_outs("R8 rewrite clears", 1'b0);
        chk("R7 trip latched after clear", W'(trip_req), 1);
        tick(N + 1);
        chk_outs("R8 stays clear", 1'b0);
        chk("R7 trip still latched", W'(trip_req), 1);
        ack();
        chk("R7 trip released", W'(trip_req), 0);
    endtask

    task automatic t_double_flip();
        flip(6);
        tick(N + 1);
        chk_outs("R4 second fault", 1'b1);
        flip(6);
        tick(N + 1);
        chk_outs("R9 cleared by scrub", 1'b0);
        ack();
        chk("R7 trip released again", W'(trip_req), 0);
    endtask

    task automatic t_multi();
        flip(1);
        flip(5);
        tick(N + 1);
        chk_outs("R4 two words bad", 1'b1);
        wr(1, model[1]);
        tick(2);
        chk_outs("R8 other word keeps hold", 1'b1);
        wr(5, model[5]);
        chk_outs("R8 both rewritten", 1'b0);
        ack();
        chk("R7 released after multi", W'(trip_req), 0);
    endtask

    task automatic t_write_wins();
        wr_en = 1'b1; wr_addr = AW'(2); wr_data = 16'hA5A4;
        inj_en = 1'b1; inj_addr = AW'(2);
        tick(1);
        wr_en = 1'b0; inj_en = 1'b0;
        model[2] = 16'hA5A4;
        tick(N + 2);
        chk_outs("R11 write beats flip", 1'b0);
        rd_addr = AW'(2); #1;
        chk("R11 data kept", rd_data, 16'hA5A4);
        chk("R11 no trip", W'(trip_req), 0);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_write_read();
        t_detect_and_rewrite();
        t_double_flip();
        t_multi();
        t_write_wins();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule